// File: doc/BRIEF.md
# Zero-Crossing Timing Quality Detector

This block grades the timing of received zero crossings as a measure of link quality. The clock recovery loop sends it one strobe per crossing, together with the signed distance in phase steps between the actual crossing and the instant the loop expected. Each crossing whose error magnitude lies inside a programmable window counts as GOOD; every other crossing is BAD.

A one-bit quality output rises only after an unbroken run of GOOD crossings and falls as soon as a BAD crossing arrives. While the receiver is in power-save, the output is held at zero. The detector keeps grading crossings even when the recovery loop and level tracker are frozen, because it looks only at the strobes it receives.

A second stage counts the recovered bit periods during which the quality output is high, over a programmable number of bits. At the end of each window it latches the total and raises a one-cycle valid pulse. Software can average these totals to estimate the signal-to-noise ratio.

Top module: `xq_quality_mon`

## Requirements
- R1: After reset, `q_out`, `hi_valid` and `hi_count` are all 0, and the run of good crossings is empty.
- R2: `xing_err` is a two's-complement phase error in steps of 1/64 bit. A crossing is GOOD when |`xing_err`| <= `good_win` and BAD otherwise. With `good_win` = 8, errors of +8 and -8 are GOOD and errors of +9 and -9 are BAD.
- R3: `q_out` becomes 1 in the cycle after the strobe that completes 4 consecutive GOOD crossings, and not before.
- R4: A BAD crossing sets `q_out` to 0 in the cycle after its strobe and empties the run, so 4 fresh GOOD crossings are needed again.
- R5: Cycles with `xing_vld` = 0 leave the run and `q_out` unchanged.
- R6: While `rx_psave` = 1, `q_out` is 0 in that same cycle and the run is emptied. After power-save ends, `q_out` stays 0 until 4 new GOOD crossings have arrived.
- R7: On every cycle with `bit_tick` = 1, the window position advances and the accumulator adds 1 if `q_out` is 1. On the tick that completes `win_bits` ticks, `hi_count` takes the total including that tick, `hi_valid` is 1 for exactly the next cycle, and a new window starts from zero.
- R8: The accumulator saturates at 2^CNT_W-1 (255 by default) and does not wrap. A 256-bit window with `q_out` held high reports 255.
- R9: A `win_bits` of 0 or 1 makes every tick close a one-bit window.
- R10: With `good_win` = 0, only a zero error is GOOD. An error of -64 is BAD for any `good_win` below 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xing_vld | input | 1 | One-cycle strobe per zero crossing |
| xing_err | input | PH_W (7) | Signed phase error of the crossing, 1/64 bit per step |
| good_win | input | PH_W (7) | Largest error magnitude still graded GOOD |
| bit_tick | input | 1 | One-cycle strobe per recovered bit period |
| rx_psave | input | 1 | Receive power-save; forces the quality output low |
| win_bits | input | WIN_W (9) | Length of the averaging window in bits |
| q_out | output | 1 | Quality output |
| hi_count | output | CNT_W (8) | High-bit total of the last completed window |
| hi_valid | output | 1 | One-cycle pulse when `hi_count` is updated |

## Verification
The hardest state to reach from the ports is a saturated accumulator that coincides with the close of a window. Getting there needs more than 255 high bit ticks in a row inside one 256-bit window, with no BAD crossing and no power-save in between. The stimulus builds a run of four GOOD crossings, then holds `bit_tick` high on every cycle for over a full window. A reference model tracks the window position across all the earlier phases, so the bench knows exactly which tick closes the window. The exact error boundaries, including the most negative error, and the release from power-save are driven as separate short phases, and each is compared cycle by cycle against the model.

// File: rtl/xq_pkg.sv
package xq_pkg;
   typedef enum logic {
      XQ_BAD  = 1'b0,
      XQ_GOOD = 1'b1
   } xq_class_e;
endpackage

// File: rtl/xq_classify.sv
module xq_classify #(
   parameter int PH_W = 7
) (
   input  logic [PH_W-1:0] err,
   input  logic [PH_W-1:0] win,
   output xq_pkg::xq_class_e cls
);
   logic [PH_W-1:0] mag;

   // magnitude of a two's-complement error; the most negative code maps to 2^(PH_W-1)
   always_comb begin
      mag = err[PH_W-1] ? (~err + 1'b1) : err;
      cls = (mag <= win) ? xq_pkg::XQ_GOOD : xq_pkg::XQ_BAD;
   end
endmodule

// File: rtl/xq_run.sv
module xq_run #(
   parameter int RUN_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld,
   input  xq_pkg::xq_class_e cls,
   input  logic              psave,
   output logic              q
);
   localparam int RUN_W = $clog2(RUN_LEN + 1);
   localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_LEN);

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (psave)
         run_q <= '0;
      else if (vld) begin
         if (cls == xq_pkg::XQ_BAD)
            run_q <= '0;
         else if (run_q != RUN_TOP)
            run_q <= run_q + 1'b1;
      end
   end

   assign q = (run_q == RUN_TOP) && !psave;

   AST_RISE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q) |-> ($past(vld) && $past(cls) == xq_pkg::XQ_GOOD) || $past(psave)); // R3
   AST_BAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && cls == xq_pkg::XQ_BAD) |=> !q); // R4
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!vld && !psave) |=> (q == $past(q)) || psave); // R5
   AST_PSAVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(psave) |-> !q); // R6
endmodule

// File: rtl/xq_avg.sv
module xq_avg #(
   parameter int WIN_W = 9,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             level,
   input  logic [WIN_W-1:0] win_bits,
   output logic [CNT_W-1:0] hi_count,
   output logic             hi_valid
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [WIN_W-1:0] wc_q;
   logic [CNT_W-1:0] acc_q;
   logic [CNT_W-1:0] acc_nx;
   logic             last;

   assign last = ({1'b0, wc_q} + 1'b1) >= {1'b0, win_bits};

   generate
      if (CNT_W > WIN_W) begin : g_plain
         // the counter cannot reach its top inside one window
         assign acc_nx = acc_q + CNT_W'(level);
      end else begin : g_sat
         assign acc_nx = (level && acc_q != CNT_MAX) ? acc_q + 1'b1 : acc_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wc_q     <= '0;
         acc_q    <= '0;
         hi_count <= '0;
         hi_valid <= 1'b0;
      end else begin
         hi_valid <= 1'b0;
         if (tick) begin
            if (last) begin
               hi_count <= acc_nx;
               hi_valid <= 1'b1;
               acc_q    <= '0;
               wc_q     <= '0;
            end else begin
               acc_q <= acc_nx;
               wc_q  <= wc_q + 1'b1;
            end
         end
      end
   end

   AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      hi_valid |-> $past(tick)); // R7
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_valid && win_bits > 1) |=> !hi_valid); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q == CNT_MAX) |=> (acc_q == CNT_MAX) || (acc_q == '0)); // R8
endmodule

// File: rtl/xq_quality_mon.sv
module xq_quality_mon #(
   parameter int PH_W    = 7,
   parameter int WIN_W   = 9,
   parameter int CNT_W   = 8,
   parameter int RUN_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xing_vld,
   input  logic [PH_W-1:0]  xing_err,
   input  logic [PH_W-1:0]  good_win,
   input  logic             bit_tick,
   input  logic             rx_psave,
   input  logic [WIN_W-1:0] win_bits,
   output logic             q_out,
   output logic [CNT_W-1:0] hi_count,
   output logic             hi_valid
);
   generate
      if (PH_W < 2) begin : g_bad_ph
         $error("PH_W must be at least 2");
      end
      if (RUN_LEN < 1) begin : g_bad_run
         $error("RUN_LEN must be at least 1");
      end
      if (WIN_W < 1 || CNT_W < 1) begin : g_bad_cnt
         $error("WIN_W and CNT_W must be positive");
      end
   endgenerate

   xq_pkg::xq_class_e cls;

   xq_classify #(.PH_W(PH_W)) u_cls (
      .err (xing_err),
      .win (good_win),
      .cls (cls)
   );

   xq_run #(.RUN_LEN(RUN_LEN)) u_run (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (xing_vld),
      .cls   (cls),
      .psave (rx_psave),
      .q     (q_out)
   );

   xq_avg #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_avg (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (bit_tick),
      .level    (q_out),
      .win_bits (win_bits),
      .hi_count (hi_count),
      .hi_valid (hi_valid)
   );

   AST_PSAVE_LOW_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_psave && $past(rx_psave)) |-> !q_out && !$past(q_out)); // R6
endmodule

// File: tb/tb_xq_quality_mon.sv
module tb_xq_quality_mon;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vld = 1'b0;
   logic [6:0] err = '0;
   logic [6:0] gwin = 7'd8;
   logic       tick = 1'b0;
   logic       ps = 1'b0;
   logic [8:0] wbits = 9'd256;
   logic       q_out;
   logic [7:0] hi_count;
   logic       hi_valid;

   int n_cmp = 0;
   int n_bad = 0;
   string cur_req = "R1";
   bit sat_seen = 0;

   // reference model state
   int m_run = 0, m_acc = 0, m_wc = 0, m_cnt = 0;
   bit m_valid = 0;

   always #2 clk = ~clk;

   xq_quality_mon dut (
      .clk(clk), .rst_n(rst_n), .xing_vld(vld), .xing_err(err),
      .good_win(gwin), .bit_tick(tick), .rx_psave(ps), .win_bits(wbits),
      .q_out(q_out), .hi_count(hi_count), .hi_valid(hi_valid)
   );

   function automatic int absval(input logic [6:0] e);
      int v;
      v = e[6] ? int'(e) - 128 : int'(e);
      return (v < 0) ? -v : v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_acc = 0; m_wc = 0; m_cnt = 0; m_valid = 0;
      end else begin
         int qn, an, wl;
         qn = (m_run >= 4 && !ps) ? 1 : 0;
         if (ps) m_run = 0;
         else if (vld) begin
            if (absval(err) <= int'(gwin)) m_run = (m_run < 4) ? m_run + 1 : 4;
            else m_run = 0;
         end
         m_valid = 0;
         if (tick) begin
            an = m_acc + qn;
            if (an > 255) an = 255;
            wl = (int'(wbits) < 1) ? 1 : int'(wbits);
            if (m_wc + 1 >= wl) begin
               m_cnt = an; m_valid = 1; m_acc = 0; m_wc = 0;
            end else begin
               m_acc = an; m_wc = m_wc + 1;
            end
         end
      end
   end

   task automatic compare();
      int eq;
      eq = (m_run >= 4 && !ps) ? 1 : 0;
      n_cmp++;
      if (q_out !== eq[0]) begin
         n_bad++;
         $display("FAIL %s q_out got %0b exp %0b", cur_req, q_out, eq[0]);
      end
      n_cmp++;
      if (hi_valid !== m_valid) begin
         n_bad++;
         $display("FAIL %s hi_valid got %0b exp %0b", cur_req, hi_valid, m_valid);
      end
      n_cmp++;
      if (hi_count !== m_cnt[7:0]) begin
         n_bad++;
         $display("FAIL %s hi_count got %0d exp %0d", cur_req, hi_count, m_cnt);
      end
      if (hi_valid && hi_count == 8'd255) sat_seen = 1;
   endtask

   task automatic cyc(input bit v, input int e, input bit t);
      @(negedge clk);
      compare();
      vld  = v;
      err  = 7'(e);
      tick = t;
   endtask

   task automatic goods(input int n);
      for (int i = 0; i < n; i++) cyc(1, (i % 2) ? -3 : 5, 0);
   endtask

   task automatic expect_q(input bit exp, input string what);
      @(negedge clk);
      compare();
      n_cmp++;
      if (q_out !== exp) begin
         n_bad++;
         $display("FAIL %s %s q_out got %0b exp %0b", cur_req, what, q_out, exp);
      end
      vld = 0; tick = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      compare();
      rst_n = 1'b1;
      cyc(0, 0, 0);

      // R3: three goods leave q low, the fourth raises it
      cur_req = "R3";
      goods(3);
      expect_q(0, "after 3 good");
      goods(4);
      expect_q(1, "after 4 good");

      // R5: idle cycles keep q high
      cur_req = "R5";
      for (int i = 0; i < 5; i++) cyc(0, 40, 0);
      expect_q(1, "idle");

      // R2: boundaries at window 8
      cur_req = "R2";
      cyc(1, 8, 0); cyc(1, -8, 0);
      expect_q(1, "+-8 good");
      cyc(1, 9, 0);
      expect_q(0, "+9 bad");
      goods(4); cyc(1, -9, 0);
      expect_q(0, "-9 bad");

      // R4: bad empties the run
      cur_req = "R4";
      goods(4); cyc(1, 30, 0); goods(3);
      expect_q(0, "3 good after bad");
      goods(1);
      expect_q(1, "4 good after bad");

      // R6: power-save forcing
      cur_req = "R6";
      @(negedge clk); compare(); vld = 0; ps = 1;
      #1;
      n_cmp++;
      if (q_out !== 1'b0) begin
         n_bad++;
         $display("FAIL R6 same-cycle q_out got %0b exp 0", q_out);
      end
      goods(2);
      @(negedge clk); compare(); vld = 0; ps = 0;
      goods(3);
      expect_q(0, "3 good after psave");
      goods(1);
      expect_q(1, "4 good after psave");

      // R10: zero window and most negative error
      cur_req = "R10";
      gwin = 7'd0;
      cyc(1, 0, 0); cyc(1, 0, 0);
      expect_q(1, "zero err good");
      cyc(1, 1, 0);
      expect_q(0, "err 1 bad at win 0");
      gwin = 7'd63;
      goods(4); cyc(1, -64, 0);
      expect_q(0, "-64 bad");
      gwin = 7'd8;

      // R7: short windows with mixed level
      cur_req = "R7";
      wbits = 9'd10;
      for (int i = 0; i < 40; i++) begin
         if (i == 12) cyc(1, 20, 1);
         else if (i >= 20 && i < 24) cyc(1, 2, 1);
         else cyc(0, 0, (i % 3) != 2);
      end

      // R9: one-bit windows
      cur_req = "R9";
      wbits = 9'd0;
      for (int i = 0; i < 6; i++) cyc(0, 0, 1);
      wbits = 9'd1;
      for (int i = 0; i < 6; i++) cyc(i == 2, 40, 1);

      // R8: saturation over a 256-bit window
      cur_req = "R8";
      cyc(0, 0, 0);
      goods(4);
      wbits = 9'd256;
      for (int i = 0; i < 600; i++) cyc(0, 0, 1);
      cyc(0, 0, 0);
      n_cmp++;
      if (!sat_seen) begin
         n_bad++;
         $display("FAIL R8 saturated total got none exp 255");
      end

      cyc(0, 0, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL %s watchdog expired got running exp finished", cur_req);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule